// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter Pair

This block holds two 16-bit count units that run from one oscillator clock. A divider turns that clock into a machine-cycle strobe, one pulse in every twelve clocks. Each unit either counts machine cycles or counts falling edges seen on its own event pin. A counting unit can also be held off by its gate pin. A shared mode byte gives each unit one of four count structures:

- a 13-bit counter built from a 5-bit prescaler and an 8-bit high byte,
- a plain 16-bit counter,
- an 8-bit counter that reloads itself from the high byte,
- a split arrangement in which unit 0 becomes two separate 8-bit counters.

Software uses a small register bus to set up both units and read them back. Writes are synchronous. Reads are combinational. Through this bus software reaches the count bytes, the mode byte, the two run bits and the two overflow flags. Each overflow flag is sticky: once set, it stays set until software clears it.

Top module: `mc_timer_pair`

## Requirements
- R1: The machine-cycle strobe acts on every 12th rising clock edge. The first strobe is the 12th rising edge after reset is released. A unit in timer function therefore cannot change before that edge.
- R2: In timer function (counter select bit = 0), an enabled unit advances by exactly one on each machine-cycle strobe.
- R3: In counter function (counter select bit = 1), the unit's event pin is sampled once per machine cycle. The count advances by one for each pair of successive samples that reads high, then low. A pin that does not change produces no count.
- R4: In mode 00 (13-bit), bits 4:0 of the low byte act as a prescaler. When they wrap from 31 to 0, the high byte advances. Bits 7:5 of the low byte never change. The unit's flag is set when the whole count wraps from 0xFF/31 to zero.
- R5: In mode 01 (16-bit), {high, low} advances as one 16-bit value. The flag is set on the wrap from 0xFFFF to 0x0000.
- R6: In mode 10 (8-bit reload), only the low byte counts. When it steps past 0xFF, it takes the value of the high byte and the unit's flag is set in that same step. The high byte does not change.
- R7: In mode 11, unit 0 splits into two 8-bit counters. The low byte uses unit 0's run bit, gate and function select, and sets flag 0. The high byte counts machine cycles whenever run bit 1 is set, and sets flag 1 when it wraps. While unit 0 is split, unit 1 keeps counting but its own wrap does not set flag 1.
- R8: Unit 1 placed in mode 11 holds its count.
- R9: A unit steps only while its run bit is 1. When its gate bit is 1, it also needs its gate pin to be high.
- R10: An overflow flag clears only when software writes 0 to its bit in the control register. If an overflow occurs on the same edge as such a write, the flag ends up set.
- R11: A bus write to either count byte of a unit suppresses that unit's step on that edge. The written byte takes the bus value and the other byte keeps its value.
- R12: Reset clears the mode byte, the control register and all four count bytes to zero.
- R13: Register map and encodings:
  - Address 0 is the mode byte: unit 0 uses bits 3:0 and unit 1 uses bits 7:4. Within each nibble, bits 1:0 hold the mode, bit 2 is the counter select and bit 3 is the gate enable.
  - Address 1 is the control register: bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1.
  - Addresses 2 and 3 are unit 0's low and high bytes. Addresses 4 and 5 are unit 1's low and high bytes.
  - All of these read back their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for bus_wdata |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ev_pin | input | 2 | Event inputs, bit n feeds unit n |
| gate_pin | input | 2 | Gate inputs, bit n gates unit n |

## Verification
The functions that can land on the same edge are a software write and a machine-cycle step. A write to the control register that clears a flag can meet the overflow that sets it. A write to a count byte can meet that unit's increment. The bench produces both collisions by counting clocks from reset release, so that the write falls on a known strobe edge. It then reads the registers back. The flag must still be set, the written byte must hold the bus value without the increment, and the unit must resume counting on the next strobe.

// File: rtl/mct_pkg.sv
package mct_pkg;
    localparam int BYTE_W  = 8;
    localparam int PRESC_W = 5;
    localparam int MC_DIV  = 12;
    localparam int ADDR_W  = 3;
    localparam int N_UNITS = 2;

    typedef enum logic [1:0] {
        MD_13B   = 2'b00,
        MD_16B   = 2'b01,
        MD_AR8   = 2'b10,
        MD_SPLIT = 2'b11
    } mode_e;

    typedef struct packed {
        logic  gate_en;
        logic  ext_src;
        mode_e mode;
    } ucfg_t;

    localparam int CFG_W = $bits(ucfg_t);

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;

    function automatic logic [ADDR_W-1:0] lo_addr(input int unit);
        return A_LO0 + ADDR_W'(2 * unit);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int unit);
        return A_LO0 + ADDR_W'(2 * unit + 1);
    endfunction
endpackage

// File: rtl/mct_phase.sv
module mct_phase #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    logic [CW-1:0] ph_q;

    assign tick = (ph_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) ph_q <= '0;
        else             ph_q <= ph_q + 1'b1;
    end
endmodule

// File: rtl/mct_edge.sv
module mct_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic [SYNC-1:0] sync_q;
    logic            smp_new, smp_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            smp_new <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], pin};
            if (tick) begin
                smp_new <= sync_q[SYNC-1];
                smp_old <= smp_new;
            end
        end
    end

    // high in one machine-cycle sample, low in the next
    assign fall = smp_old & ~smp_new;
endmodule

// File: rtl/mct_unit.sv
module mct_unit
    import mct_pkg::*;
#(
    parameter bit SPLIT_OWNER = 1'b0,
    parameter int BW          = BYTE_W,
    parameter int PW          = PRESC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          step,
    input  logic          step_hi,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi,
    output logic          ovf_main,
    output logic          ovf_aux
);
    localparam logic [BW-1:0] ONES = '1;

    logic [BW-1:0]   lo_n, hi_n, sp_lo, sp_hi;
    logic            sp_ova, sp_ovb;
    logic [PW:0]     presc;
    logic [2*BW:0]   wide;

    generate
        if (SPLIT_OWNER) begin : g_split
            assign sp_lo  = step    ? lo + 1'b1 : lo;
            assign sp_hi  = step_hi ? hi + 1'b1 : hi;
            assign sp_ova = step    & (lo == ONES);
            assign sp_ovb = step_hi & (hi == ONES);
        end else begin : g_hold
            assign sp_lo  = lo;
            assign sp_hi  = hi;
            assign sp_ova = 1'b0;
            assign sp_ovb = 1'b0;
        end
    endgenerate

    always_comb begin
        presc    = {1'b0, lo[PW-1:0]} + 1'b1;
        wide     = {1'b0, hi, lo} + 1'b1;
        lo_n     = lo;
        hi_n     = hi;
        ovf_main = 1'b0;
        ovf_aux  = 1'b0;
        if (!(wr_lo || wr_hi)) begin
            case (mode)
                MD_13B: if (step) begin
                    lo_n[PW-1:0] = presc[PW-1:0];
                    if (presc[PW]) begin
                        hi_n     = hi + 1'b1;
                        ovf_main = (hi == ONES);
                    end
                end
                MD_16B: if (step) begin
                    {hi_n, lo_n} = wide[2*BW-1:0];
                    ovf_main     = wide[2*BW];
                end
                MD_AR8: if (step) begin
                    if (lo == ONES) begin
                        lo_n     = hi;
                        ovf_main = 1'b1;
                    end else begin
                        lo_n = lo + 1'b1;
                    end
                end
                default: begin
                    lo_n     = sp_lo;
                    hi_n     = sp_hi;
                    ovf_main = sp_ova;
                    ovf_aux  = sp_ovb;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wdata : lo_n;
            hi <= wr_hi ? wdata : hi_n;
        end
    end
endmodule

// File: rtl/mc_timer_pair.sv
module mc_timer_pair
    import mct_pkg::*;
#(
    parameter int DIV  = MC_DIV,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [1:0]        ev_pin,
    input  logic [1:0]        gate_pin
);
    localparam int BW = BYTE_W;

    logic [BW-1:0]      mode_q;
    logic [N_UNITS-1:0] run_q, flag_q, flag_set;
    logic [N_UNITS-1:0] fall, step, ovf_main, ovf_aux, wr_lo, wr_hi;
    logic [BW-1:0]      lo_q [N_UNITS];
    logic [BW-1:0]      hi_q [N_UNITS];
    ucfg_t              cfg  [N_UNITS];
    logic               mc_tick, split0;

    mct_phase #(.DIV(DIV)) u_phase (.clk(clk), .rst(rst), .tick(mc_tick));

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            assign cfg[u]   = ucfg_t'(mode_q[CFG_W*u +: CFG_W]);
            assign wr_lo[u] = bus_wr && (bus_addr == lo_addr(u));
            assign wr_hi[u] = bus_wr && (bus_addr == hi_addr(u));
            assign step[u]  = mc_tick && run_q[u]
                              && (!cfg[u].gate_en || gate_pin[u])
                              && (!cfg[u].ext_src || fall[u]);

            mct_edge #(.SYNC(SYNC)) u_edge (
                .clk(clk), .rst(rst), .tick(mc_tick),
                .pin(ev_pin[u]), .fall(fall[u])
            );

            mct_unit #(.SPLIT_OWNER(u == 0)) u_cnt (
                .clk(clk), .rst(rst), .mode(cfg[u].mode),
                .step(step[u]), .step_hi(mc_tick && run_q[1]),
                .wr_lo(wr_lo[u]), .wr_hi(wr_hi[u]), .wdata(bus_wdata),
                .lo(lo_q[u]), .hi(hi_q[u]),
                .ovf_main(ovf_main[u]), .ovf_aux(ovf_aux[u])
            );
        end
    endgenerate

    // split unit 0 takes flag 1 away from unit 1
    assign split0   = (cfg[0].mode == MD_SPLIT);
    assign flag_set = {split0 ? ovf_aux[0] : ovf_main[1], ovf_main[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata;
            if (bus_wr && bus_addr == A_CTRL) begin
                run_q  <= bus_wdata[1:0];
                flag_q <= bus_wdata[3:2] | flag_set;
            end else begin
                flag_q <= flag_q | flag_set;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MODE)      bus_rdata = mode_q;
        else if (bus_addr == A_CTRL) bus_rdata = {{(BW-4){1'b0}}, flag_q, run_q};
        for (int u = 0; u < N_UNITS; u++) begin
            if (bus_addr == lo_addr(u)) bus_rdata = lo_q[u];
            if (bus_addr == hi_addr(u)) bus_rdata = hi_q[u];
        end
    end
endmodule

// File: rtl/mct_checker.sv
module mct_checker
    import mct_pkg::*;
#(
    parameter int DIV = MC_DIV
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [7:0]        mode_q,
    input logic [1:0]        run_q,
    input logic [1:0]        flag_q,
    input logic [7:0]        lo0,
    input logic [7:0]        hi0,
    input logic [7:0]        lo1,
    input logic [7:0]        hi1,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);
    logic [$clog2(DIV)-1:0] gap;
    logic wr_u0, wr_lo0, wr_u1, wr_ctrl;

    assign wr_lo0  = bus_wr && bus_addr == lo_addr(0);
    assign wr_u0   = wr_lo0 || (bus_wr && bus_addr == hi_addr(0));
    assign wr_u1   = bus_wr && (bus_addr == lo_addr(1) || bus_addr == hi_addr(1));
    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;

    always_ff @(posedge clk) begin
        if (rst || tick) gap <= '0;
        else             gap <= gap + 1'b1;
    end

    assert_strobe_period_R1: assert property (@(posedge clk) disable iff (rst)
        tick == (gap == ($clog2(DIV))'(DIV - 1)));

    assert_presc_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q[1:0] == MD_13B && !wr_lo0) |=> $stable(lo0[7:5]));

    assert_split_u1_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q[5:4] == MD_SPLIT && !wr_u1) |=> $stable({hi1, lo1}));

    assert_run_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!run_q[0] && mode_q[1:0] != MD_SPLIT && !wr_u0) |=> $stable({hi0, lo0}));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_q[0] && !wr_ctrl) |=> flag_q[0]);

    assert_flag1_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_q[1] && !wr_ctrl) |=> flag_q[1]);
endmodule

bind mc_timer_pair mct_checker #(.DIV(DIV)) u_chk (
    .clk(clk), .rst(rst), .tick(mc_tick), .mode_q(mode_q), .run_q(run_q),
    .flag_q(flag_q), .lo0(lo_q[0]), .hi0(hi_q[0]), .lo1(lo_q[1]), .hi1(hi_q[1]),
    .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/sim_mc_timer_pair.sv
module sim_mc_timer_pair;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ev_pin = '0;
    logic [1:0] gate_pin = '0;
    int         n_chk = 0;
    int         n_err = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    localparam logic [2:0] MODE = 3'd0, CTRL = 3'd1, LO0 = 3'd2, HI0 = 3'd3,
                           LO1 = 3'd4, HI1 = 3'd5;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    mc_timer_pair u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pin(ev_pin), .gate_pin(gate_pin)
    );

    // {mode, lo, hi, run, ticks, exp lo, exp hi, exp ctrl}, req tag
    localparam logic [63:0] VEC [8] = '{
        64'h01_FE_FF_01_03_01_00_04,  // R5 wrap 0xFFFF, flag 0
        64'h00_FE_12_01_03_E1_13_00,  // R4 prescale carry, bits 7:5 kept
        64'h00_1F_FF_01_01_00_00_04,  // R4 full 13-bit wrap
        64'h02_FE_80_01_04_82_80_04,  // R6 reload from high byte
        64'h03_FF_FE_03_02_01_00_0C,  // R7 both split halves wrap
        64'h03_10_20_01_05_15_20_00,  // R7 high half needs run 1
        64'h01_33_44_00_03_33_44_00,  // R9 run off holds
        64'h09_50_60_01_02_50_60_00   // R9 gate pin low holds
    };
    localparam int VREQ [8] = '{5, 4, 4, 6, 7, 7, 9, 9};

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] act;
        rd(a, act);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        logic [7:0] c;
        do_reset();
        // R12 reset state
        chk("R12", MODE, 8'h00);
        chk("R12", CTRL, 8'h00);
        chk("R12", LO0, 8'h00);
        chk("R12", HI1, 8'h00);

        for (int i = 0; i < 8; i++) begin
            logic [63:0] v;
            string t;
            v = VEC[i];
            t = $sformatf("R%0d vec%0d", VREQ[i], i);
            wr(CTRL, 8'h00);
            wr(MODE, v[63:56]);
            wr(LO0, v[55:48]);
            wr(HI0, v[47:40]);
            wr(CTRL, v[39:32]);
            repeat (12 * int'(v[31:24]) - 1) @(negedge clk);
            rd(CTRL, c);
            wr(CTRL, {4'h0, c[3:2], 2'b00});
            chk(t, LO0, v[23:16]);
            chk(t, HI0, v[15:8]);
            chk(t, CTRL, v[7:0]);
        end

        // R1 R10 R11 R2: collisions on known strobe edges
        do_reset();
        wr(MODE, 8'h01);
        wr(LO0, 8'hFF);
        wr(HI0, 8'hFF);
        wr(CTRL, 8'h01);
        wait_cyc(11);
        chk("R1", LO0, 8'hFF);
        wr(CTRL, 8'h01);              // clear lands on the wrap edge
        chk("R10", CTRL, 8'h05);
        chk("R5", HI0, 8'h00);
        wait_cyc(23);
        wr(LO0, 8'h50);               // write lands on a strobe edge
        chk("R11", LO0, 8'h50);
        chk("R11", HI0, 8'h00);
        wait_cyc(36);
        chk("R2", LO0, 8'h51);
        wr(CTRL, 8'h01);
        chk("R10", CTRL, 8'h01);

        // R9 gate pin high lets unit 0 count, low stops it
        do_reset();
        wr(MODE, 8'h09);
        wr(CTRL, 8'h01);
        gate_pin[0] = 1'b1;
        wait_cyc(30);
        chk("R9", LO0, 8'h02);
        gate_pin[0] = 1'b0;
        wait_cyc(50);
        chk("R9", LO0, 8'h02);

        // R3 counter function on unit 1
        do_reset();
        wr(MODE, 8'h50);
        wr(CTRL, 8'h02);
        for (int k = 0; k < 4; k++) begin
            ev_pin[1] = 1'b1;
            repeat (24) @(negedge clk);
            ev_pin[1] = 1'b0;
            repeat (24) @(negedge clk);
        end
        repeat (48) @(negedge clk);
        chk("R3", LO1, 8'h04);
        chk("R3", HI1, 8'h00);
        repeat (60) @(negedge clk);
        chk("R3", LO1, 8'h04);

        // R7 unit 1 wrap ignored while unit 0 split; R8 unit 1 split holds
        do_reset();
        wr(MODE, 8'h13);
        wr(LO1, 8'hFF);
        wr(HI1, 8'hFF);
        wr(CTRL, 8'h02);
        wait_cyc(30);
        chk("R7", LO1, 8'h01);
        chk("R7", HI1, 8'h00);
        chk("R7", HI0, 8'h02);
        chk("R7", LO0, 8'h00);
        chk("R7", CTRL, 8'h02);
        wr(MODE, 8'h33);
        wait_cyc(58);
        chk("R8", LO1, 8'h01);
        chk("R8", HI1, 8'h00);
        chk("R8", HI0, 8'h04);
        chk("R13", MODE, 8'h33);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule